// File: doc/BRIEF.md
# Receive Frame Error Statistics Counters

This block holds three 32-bit statistics counters for an Ethernet receive path: one for frames with a bad CRC, one for frames with an alignment fault (dribbling bits), and one for frames dropped because no buffer was free or the receive FIFO overran. The receiver raises a one-cycle end-of-frame strobe carrying five status flags. The block sorts each frame into at most one counter by a fixed precedence. Drop conditions come first, then alignment, then CRC. CRC and alignment faults count only for frames addressed to this station.

Software reaches the counters through a small register port. Reads are combinational and allowed at any time. Writes preset a counter, and they take effect only while the receive channel is disabled. A write attempted while the channel is enabled is dropped, and an error bit is raised on the port for one cycle. Every counter wraps modulo 2^32.

Top module: `rxstat_top`

## Requirements
- R1: After synchronous active-low reset, all three counters read zero and `reg_wr_err` is low.
- R2: A strobed frame with `eof_match`=1, `eof_crc_bad`=1, `eof_no_buf`=0, `eof_overrun`=0 and `eof_dribble`=0 increments the CRC counter (address 0) by one. The new value is visible from the cycle after the strobe.
- R3: A strobed frame with `eof_match`=1, `eof_dribble`=1, `eof_no_buf`=0 and `eof_overrun`=0 increments the alignment counter (address 1) by one, whatever the value of `eof_crc_bad`.
- R4: A strobed frame with `eof_no_buf`=1 or `eof_overrun`=1 increments the discard counter (address 2) by one, whatever the values of `eof_match`, `eof_crc_bad` and `eof_dribble`.
- R5: A strobed frame that is neither dropped nor faulted, or that has `eof_match`=0 and no drop condition, leaves all counters unchanged.
- R6: A single strobe advances at most one counter, and by exactly one.
- R7: A counter at 0xFFFFFFFF that increments wraps to 0.
- R8: A write with `chan_en`=0 loads `reg_wdata` into the counter selected by `reg_addr`. The new value is visible the next cycle, and `reg_wr_err` stays low.
- R9: A write with `chan_en`=1 changes no counter, and `reg_wr_err` is high for exactly the cycle after it.
- R10: When a write and an increment hit the same counter in the same cycle, the counter becomes its previous value plus one, and the written data is lost.
- R11: Address map: 0 CRC, 1 alignment, 2 discard. Address 3 reads zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Receive channel enabled; blocks software writes |
| eof_valid | input | 1 | End-of-frame status strobe, one cycle |
| eof_match | input | 1 | Frame was addressed to this station |
| eof_no_buf | input | 1 | Frame dropped: no receive buffer available |
| eof_overrun | input | 1 | Frame dropped: receive FIFO overrun |
| eof_crc_bad | input | 1 | Frame check sequence mismatch |
| eof_dribble | input | 1 | Frame ended on a non-octet boundary |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| reg_wr_err | output | 1 | Rejected write flag, one cycle after the write |

## Verification
The hardest case to reach is a software write and a hardware increment landing on the same counter in the same cycle. Legal software never causes it, because writes are only accepted while the channel is disabled. The bench therefore drops `chan_en` and, in one cycle, drives a drop-flagged strobe together with a write to the discard counter. It then checks that the counter holds its old value plus one. The precedence rules are covered by strobes that combine several fault flags at once, such as CRC together with dribble, and CRC together with overrun on an unmatched frame, so that each masking term is tested on its own.

// File: rtl/rxstat_pkg.sv
// Shared constants and types for the receive statistics block.
// Assumes: counters are indexed 0..NUM_CNT-1 in the order below; the
// register map uses these same indices as addresses.
package rxstat_pkg;
    localparam int NUM_CNT = 3;
    localparam int IDX_CRC = 0;
    localparam int IDX_ALN = 1;
    localparam int IDX_DIS = 2;

    // Per-frame status reported by the receiver at end of frame
    typedef struct packed {
        logic match;
        logic no_buf;
        logic overrun;
        logic crc_bad;
        logic dribble;
    } frame_flags_t;
endpackage

// File: rtl/rxstat_classify.sv
// Frame classifier: turns one end-of-frame status strobe into at most one
// counter increment request, by precedence drop > alignment > CRC.
// Assumes: eof_valid is a single-cycle strobe; flags are valid with it.
module rxstat_classify
    import rxstat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               eof_valid,
    input  frame_flags_t       flags,
    output logic [NUM_CNT-1:0] inc
);
    logic dropped;
    logic aln_fault;
    logic crc_fault;

    // Decide the single counter this frame belongs to
    always_comb begin
        dropped   = flags.no_buf | flags.overrun;
        aln_fault = flags.match & flags.dribble & ~dropped;
        crc_fault = flags.match & flags.crc_bad & ~flags.dribble & ~dropped;
        inc          = '0;
        inc[IDX_DIS] = eof_valid & dropped;
        inc[IDX_ALN] = eof_valid & aln_fault;
        inc[IDX_CRC] = eof_valid & crc_fault;
    end

    // R6: the request lines never select more than one counter
    a_r6_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inc));

    // R5: without a strobe no request is raised
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !eof_valid |-> (inc == '0));
endmodule

// File: rtl/rxstat_counter.sv
// One statistics counter with a software preset.
// Assumes: inc and ld are single-cycle; inc has priority over ld.
module rxstat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt
);
    // Hold, increment (wrapping) or preset the count
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (inc) cnt <= cnt + W'(1);
        else if (ld)  cnt <= ld_val;
    end

    // R7/R10: an increment always yields previous value plus one, modulo 2^W
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (cnt == $past(cnt) + W'(1)));

    // R8: a preset without a competing increment takes the written value
    a_r8_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !inc) |=> (cnt == $past(ld_val)));

    // R6: with no request the count holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !inc) |=> $stable(cnt));
endmodule

// File: rtl/rxstat_regport.sv
// Register port: read mux, write gating by channel state, reject flag.
// Assumes: addresses at or above NUM_CNT are unmapped (read zero).
module rxstat_regport
    import rxstat_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      chan_en,
    input  logic                      reg_wr,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [W-1:0]              reg_wdata,
    input  logic [NUM_CNT-1:0][W-1:0] cnt_bus,
    output logic [NUM_CNT-1:0]        ld,
    output logic [W-1:0]              ld_val,
    output logic [W-1:0]              rdata,
    output logic                      wr_err
);
    logic wr_ok;

    assign wr_ok  = reg_wr & ~chan_en;
    assign ld_val = reg_wdata;

    // One load strobe per counter, decoded from the address
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
        assign ld[i] = wr_ok & (reg_addr == ADDR_W'(i));
    end

    // Read mux; unmapped addresses return zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (reg_addr == ADDR_W'(i)) rdata = cnt_bus[i];
        end
    end

    // Flag a write attempted while the channel runs
    always_ff @(posedge clk) begin
        if (!rst_n) wr_err <= 1'b0;
        else        wr_err <= reg_wr & chan_en;
    end

    // R9: a rejected write raises the flag on the next cycle
    a_r9_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && chan_en) |=> wr_err);

    // R8: an accepted or absent write leaves the flag low
    a_r8_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && chan_en) |=> !wr_err);
endmodule

// File: rtl/rxstat_top.sv
// Receive frame error statistics: three wrapping counters fed by an
// end-of-frame status strobe, with a gated software register port.
// Assumes: eof_valid is one cycle per frame; software writes only while
// chan_en is low, and writes are rejected otherwise.
module rxstat_top
    import rxstat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              eof_valid,
    input  logic              eof_match,
    input  logic              eof_no_buf,
    input  logic              eof_overrun,
    input  logic              eof_crc_bad,
    input  logic              eof_dribble,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              reg_wr_err
);
    frame_flags_t                  flags;
    logic [NUM_CNT-1:0]            inc;
    logic [NUM_CNT-1:0]            ld;
    logic [CNT_W-1:0]              ld_val;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_bus;

    // Gather the status inputs into one record
    always_comb begin
        flags.match   = eof_match;
        flags.no_buf  = eof_no_buf;
        flags.overrun = eof_overrun;
        flags.crc_bad = eof_crc_bad;
        flags.dribble = eof_dribble;
    end

    rxstat_classify i_classify (
        .clk       (clk),
        .rst_n     (rst_n),
        .eof_valid (eof_valid),
        .flags     (flags),
        .inc       (inc)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        rxstat_counter #(.W(CNT_W)) i_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (inc[i]),
            .ld     (ld[i]),
            .ld_val (ld_val),
            .cnt    (cnt_bus[i])
        );
    end

    rxstat_regport #(.W(CNT_W), .ADDR_W(ADDR_W)) i_regport (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en   (chan_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cnt_bus   (cnt_bus),
        .ld        (ld),
        .ld_val    (ld_val),
        .rdata     (reg_rdata),
        .wr_err    (reg_wr_err)
    );

    // R4: a dropped frame advances the discard count by one
    a_r4_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_valid && (eof_no_buf || eof_overrun))
        |=> (cnt_bus[IDX_DIS] == $past(cnt_bus[IDX_DIS]) + CNT_W'(1)));

    // R5: an unaddressed, undropped frame with no write changes nothing
    a_r5_unmatched: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_valid && !eof_match && !eof_no_buf && !eof_overrun && !reg_wr)
        |=> $stable(cnt_bus));

    // R9: a write while the channel runs, with no frame, changes nothing
    a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && chan_en && !eof_valid) |=> $stable(cnt_bus));

    // R3: alignment fault on an addressed, undropped frame is counted
    a_r3_align: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_valid && eof_match && eof_dribble && !eof_no_buf && !eof_overrun)
        |=> (cnt_bus[IDX_ALN] == $past(cnt_bus[IDX_ALN]) + CNT_W'(1)));
endmodule

// File: tb/test_rxstat_top.sv
module test_rxstat_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0;
    logic        eof_valid = 1'b0;
    logic        eof_match = 1'b0;
    logic        eof_no_buf = 1'b0;
    logic        eof_overrun = 1'b0;
    logic        eof_crc_bad = 1'b0;
    logic        eof_dribble = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        reg_wr_err;

    int checks = 0;
    int errors = 0;
    logic [31:0] m [3];
    logic mon_go = 1'b0;
    logic done = 1'b0;

    typedef struct {
        bit          is_err;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    rxstat_top i_rxstat_top (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
        .eof_valid(eof_valid), .eof_match(eof_match), .eof_no_buf(eof_no_buf),
        .eof_overrun(eof_overrun), .eof_crc_bad(eof_crc_bad),
        .eof_dribble(eof_dribble), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_wr_err(reg_wr_err)
    );

    // Monitor: pop the next expectation and compare against the port
    always @(negedge clk) begin
        if (mon_go && sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            act = it.is_err ? {31'd0, reg_wr_err} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    // Push one expectation and let the monitor sample it at the next negedge
    task automatic expect_item(input bit is_err, input logic [1:0] a,
                               input logic [31:0] v, input string tag);
        item_t it;
        if (!is_err) reg_addr = a;
        it.is_err = is_err; it.exp = v; it.tag = tag;
        sb.push_back(it);
        mon_go = 1'b1;
        @(negedge clk);
        #1 mon_go = 1'b0;
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            expect_item(1'b0, 2'(i), m[i], tag);
        end
    endtask

    // Drive one cycle of frame and/or write, update the reference model
    task automatic cycle(input bit wr, input logic [1:0] a, input logic [31:0] d,
                         input bit fv, input logic [4:0] f, input string tag);
        bit incd [3];
        @(posedge clk); #1;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        eof_valid = fv;
        {eof_match, eof_no_buf, eof_overrun, eof_crc_bad, eof_dribble} = f;
        incd[2] = fv && (f[3] || f[2]);
        incd[1] = fv && f[4] && f[0] && !incd[2];
        incd[0] = fv && f[4] && f[1] && !f[0] && !(f[3] || f[2]);
        for (int i = 0; i < 3; i++) begin
            if (incd[i]) m[i] = m[i] + 32'd1;
            else if (wr && !chan_en && a == 2'(i)) m[i] = d;
        end
        @(posedge clk); #1;
        expect_item(1'b1, 2'd0, {31'd0, wr && chan_en}, tag);
        reg_wr = 1'b0; eof_valid = 1'b0;
        {eof_match, eof_no_buf, eof_overrun, eof_crc_bad, eof_dribble} = 5'd0;
    endtask

    // flags order: {match, no_buf, overrun, crc_bad, dribble}
    initial begin
        for (int i = 0; i < 3; i++) m[i] = 32'd0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_all("R1 reset value");
        @(posedge clk); #1;
        expect_item(1'b1, 2'd0, 32'd0, "R1 error flag at reset");

        chan_en = 1'b1;
        cycle(0, 0, 0, 1, 5'b10010, "R2 crc frame");
        cycle(0, 0, 0, 1, 5'b10010, "R2 crc frame again");
        check_all("R2 crc counted");
        cycle(0, 0, 0, 1, 5'b10001, "R3 dribble frame");
        cycle(0, 0, 0, 1, 5'b10011, "R3 dribble masks crc");
        check_all("R3 R6 alignment precedence");
        cycle(0, 0, 0, 1, 5'b11010, "R4 no-buffer with crc");
        cycle(0, 0, 0, 1, 5'b00111, "R4 overrun unmatched");
        cycle(0, 0, 0, 1, 5'b10101, "R4 overrun masks dribble");
        check_all("R4 R6 discard precedence");
        cycle(0, 0, 0, 1, 5'b00010, "R5 unmatched crc");
        cycle(0, 0, 0, 1, 5'b00001, "R5 unmatched dribble");
        cycle(0, 0, 0, 1, 5'b10000, "R5 good frame");
        check_all("R5 no count");

        cycle(1, 0, 32'h5555_0000, 0, 5'd0, "R9 write while enabled flags");
        check_all("R9 write ignored");

        chan_en = 1'b0;
        cycle(1, 0, 32'hFFFF_FFFF, 0, 5'd0, "R8 write accepted no flag");
        cycle(1, 1, 32'h0000_1234, 0, 5'd0, "R8 write align");
        cycle(1, 2, 32'hABCD_EF00, 0, 5'd0, "R8 write discard");
        cycle(1, 3, 32'h1111_1111, 0, 5'd0, "R11 write unmapped");
        check_all("R8 R11 preset values");
        @(posedge clk); #1;
        expect_item(1'b0, 2'd3, 32'd0, "R11 unmapped reads zero");

        chan_en = 1'b1;
        cycle(0, 0, 0, 1, 5'b10010, "R7 crc at all ones");
        check_all("R7 wrap to zero");

        chan_en = 1'b0;
        cycle(1, 2, 32'h0000_0005, 1, 5'b01000, "R10 write meets increment");
        check_all("R10 increment wins");
        cycle(1, 1, 32'h0000_0077, 1, 5'b10010, "R10 write other counter");
        check_all("R10 disjoint write and increment");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is one failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule